// File: doc/BRIEF.md
# Data Address Translator with Fault Status

This block turns the address of a load or store into a physical address and, when the access cannot go ahead, reports which kind of fault it raised. A request carries the virtual address, an access size code, a store flag, four request qualifiers (physical, alternate mode, page-table-entry load, no-fault), the address space number and the opcode and register fields of the instruction. The block sends the page number and address space number to an external translation buffer and takes its hit, page frame, per-mode read and write enables and fault-on-read and fault-on-write marks back in the same cycle.

Requests enter through a valid/ready handshake and results leave through a second one, one cycle after acceptance. A request is accepted only while the result slot is empty or is being drained in that same cycle. While the consumer holds ready low, the result stays put and no new request is taken. Three fault registers (faulting address, fault status word, formatted address) are plain outputs. They are written when a faulting request is accepted.

Top module: `dtx_xlate`

## Requirements
- R1: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. An accepted request shows up on `rsp_valid`/`rsp_paddr`/`rsp_fault` on the next clock edge. The result is held unchanged while `rsp_ready` is low.
- R2: With size code s (2^s bytes), an address with any of bits s-1..0 set gives fault code 1 (alignment), ahead of every other check. Its status flags hold only the write bit, which equals `req_store`.
- R3: The effective mode is `alt_mode` when `req_alt` is set and `cur_mode` otherwise. Mode 0 is kernel, and the enable bit used for a mode is the bit whose index equals the mode.
- R4: A physical request gives `rsp_paddr` = the low 44 bits of the address with no translation-buffer checks. It gives fault code 6 (machine check) if any address bit at position 41 or above is set, and code 0 otherwise.
- R5: For a non-physical request, if address bits 47..42 are not all equal, the result is fault code 5 (page fault) with status flags bad-address, access-violation and write.
- R6: With `sp_en` high and address bits 47..41 equal to 0x7E, a kernel-mode request gives code 0 and `rsp_paddr` = address bits 40..0. Any other mode gives code 4 (access violation) with flags access-violation and write.
- R7: A translation-buffer miss gives code 2 for a page-table-entry load and code 3 otherwise, with flags miss and write.
- R8: On a hit, a store whose mode write-enable is clear gives code 4 with flags write and access-violation, plus fault-on-write if the entry has it. An enabled store to a fault-on-write entry gives code 5 with flags write and fault-on-write.
- R9: On a hit, a load whose mode read-enable is clear gives code 4 with flag access-violation, plus fault-on-read if the entry has it. An enabled load of a fault-on-read entry gives code 5 with flag fault-on-read.
- R10: A permitted hit gives `rsp_paddr` = {`tlb_ppn`, address bits 12..0}. It gives code 6 if bits 43..41 of that result are not all zero, and code 0 otherwise.
- R11: The status word is 17 bits: opcode in bits 16..11, register field in bits 10..6, and flags write=0, access-violation=1, fault-on-read=2, fault-on-write=3, bad-address=4, miss=5.
- R12: Accepting a request with fault code 1 to 5 and neither `req_pte` nor `req_nofault` sets `flt_va` to the address, `flt_stat` to the status word and `flt_form` to `pt_base` ORed with (address bits 47..13 shifted left by 3). No other request changes these registers.
- R13: `lkp_vpn` equals address bits 47..13 and `lkp_asn` equals `req_asn`, combinationally from the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_va | input | 48 | Virtual address |
| req_size | input | 2 | Access size code, 2^code bytes |
| req_store | input | 1 | Access is a store |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Use alternate mode |
| req_pte | input | 1 | Page-table-entry load |
| req_nofault | input | 1 | Do not record fault registers |
| req_asn | input | 8 | Address space number |
| req_opcode | input | 6 | Instruction opcode field |
| req_ra | input | 5 | Instruction register field |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode register |
| sp_en | input | 1 | Superpage window enable |
| pt_base | input | 48 | Page-table base for formatted address |
| lkp_vpn | output | 35 | Lookup page number to translation buffer |
| lkp_asn | output | 8 | Lookup address space number |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 31 | Physical page frame |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_for | input | 1 | Fault-on-read mark |
| tlb_fow | input | 1 | Fault-on-write mark |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_paddr | output | 44 | Physical address |
| rsp_fault | output | 3 | Fault code: 0 none, 1 align, 2 primary miss, 3 normal miss, 4 violation, 5 page, 6 machine check |
| flt_va | output | 48 | Faulting address register |
| flt_stat | output | 17 | Fault status register |
| flt_form | output | 48 | Formatted address register |

## Verification
The properties assume the translation-buffer result is valid during the cycle a request is accepted. They also assume the size code is always in range and the request fields do not need to stay stable after acceptance. The stimulus updates all request and lookup inputs together, half a cycle before the accepting edge. It keeps `req_valid` high for exactly one edge, except in the back-pressure sequence, where the request is held until it is taken. Each sweep pairs a lookup result with the request it answers, so no property ever sees stale translation data.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_ALIGN     = 3'd1,
    FLT_MISS_PTE  = 3'd2,
    FLT_MISS_DATA = 3'd3,
    FLT_ACV       = 3'd4,
    FLT_PAGE      = 3'd5,
    FLT_MCHK      = 3'd6
  } flt_e;

  localparam int NFLAG   = 6;
  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_FOR  = 2;
  localparam int ST_FOW  = 3;
  localparam int ST_BAD  = 4;
  localparam int ST_MISS = 5;

  localparam int OPC_W   = 6;
  localparam int RA_W    = 5;
  localparam int STAT_W  = OPC_W + RA_W + NFLAG;

  localparam int MODE_W  = 2;
  localparam int NMODE   = 1 << MODE_W;
  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;
endpackage

// File: rtl/dtx_align.sv
module dtx_align #(
  parameter int SZW   = 2,
  parameter int LOW_W = (1 << SZW) - 1
) (
  input  logic [SZW-1:0]   size_code,
  input  logic [LOW_W-1:0] va_lo,
  output logic             misaligned
);
  logic [LOW_W-1:0] mask;

  // A low address bit must be clear whenever it lies inside the access size.
  for (genvar i = 0; i < LOW_W; i++) begin : g_mask
    assign mask[i] = (int'(size_code) > i);
  end

  assign misaligned = |(va_lo & mask);
endmodule

// File: rtl/dtx_classify.sv
module dtx_classify
  import dtx_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 44,
  parameter int PA_IMPL = 41,
  parameter int VA_IMPL = 43,
  parameter int PG_SH   = 13,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 126,
  parameter int PPN_W   = PA_W - PG_SH
) (
  input  logic [VA_W-1:0]   va,
  input  logic              is_store,
  input  logic              phys,
  input  logic              pte_load,
  input  logic              misaligned,
  input  logic [MODE_W-1:0] mode_eff,
  input  logic              sp_en,
  input  logic              hit,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [NMODE-1:0]  rd_en,
  input  logic [NMODE-1:0]  wr_en,
  input  logic              f_or,
  input  logic              f_ow,
  output flt_e              fault,
  output logic [NFLAG-1:0]  flags,
  output logic [PA_W-1:0]   paddr
);
  localparam int SPW = VA_W - SP_LO;
  localparam int HIW = VA_W - VA_IMPL + 1;

  logic [HIW-1:0] va_hi;
  logic           va_bad;
  logic           in_sp;
  logic [PA_W-1:0] xl_pa;

  assign va_hi  = va[VA_W-1:VA_IMPL-1];
  assign va_bad = !((&va_hi) || !(|va_hi));
  assign in_sp  = sp_en && (va[VA_W-1:SP_LO] == SPW'(SP_TAG));
  assign xl_pa  = {ppn, va[PG_SH-1:0]};

  always_comb begin
    fault = FLT_NONE;
    flags = '0;
    paddr = '0;
    if (misaligned) begin
      fault         = FLT_ALIGN;
      flags[ST_WR]  = is_store;
    end else if (phys) begin
      paddr = va[PA_W-1:0];
      if (|va[VA_W-1:PA_IMPL]) fault = FLT_MCHK;
    end else if (va_bad) begin
      fault          = FLT_PAGE;
      flags[ST_WR]   = is_store;
      flags[ST_BAD]  = 1'b1;
      flags[ST_ACV]  = 1'b1;
    end else if (in_sp) begin
      if (mode_eff == MODE_KERNEL) begin
        paddr = PA_W'(va[PA_IMPL-1:0]);
      end else begin
        fault         = FLT_ACV;
        flags[ST_WR]  = is_store;
        flags[ST_ACV] = 1'b1;
      end
    end else if (!hit) begin
      fault          = pte_load ? FLT_MISS_PTE : FLT_MISS_DATA;
      flags[ST_WR]   = is_store;
      flags[ST_MISS] = 1'b1;
    end else begin
      paddr = xl_pa;
      if (is_store) begin
        flags[ST_WR] = 1'b1;
        if (!wr_en[mode_eff]) begin
          fault         = FLT_ACV;
          flags[ST_ACV] = 1'b1;
          flags[ST_FOW] = f_ow;
        end else if (f_ow) begin
          fault         = FLT_PAGE;
          flags[ST_FOW] = 1'b1;
        end
      end else begin
        if (!rd_en[mode_eff]) begin
          fault         = FLT_ACV;
          flags[ST_ACV] = 1'b1;
          flags[ST_FOR] = f_or;
        end else if (f_or) begin
          fault         = FLT_PAGE;
          flags[ST_FOR] = 1'b1;
        end
      end
      if (fault == FLT_NONE && (|xl_pa[PA_W-1:PA_IMPL])) fault = FLT_MCHK;
    end
  end
endmodule

// File: rtl/dtx_status.sv
module dtx_status
  import dtx_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PG_SH = 13
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [RA_W-1:0]   ra,
  input  logic [NFLAG-1:0]  flags,
  input  logic [VA_W-1:0]   va,
  input  logic [VA_W-1:0]   pt_base,
  output logic [STAT_W-1:0] stat,
  output logic [VA_W-1:0]   form
);
  localparam int VPN_W = VA_W - PG_SH;

  logic [VPN_W-1:0] vpn;
  assign vpn  = va[VA_W-1:PG_SH];
  assign stat = {opcode, ra, flags};
  assign form = pt_base | VA_W'({vpn, 3'b000});
endmodule

// File: rtl/dtx_fault_regs.sv
module dtx_fault_regs
  import dtx_pkg::*;
#(
  parameter int VA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [VA_W-1:0]   va_in,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [VA_W-1:0]   form_in,
  output logic [VA_W-1:0]   va_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [VA_W-1:0]   form_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      stat_q <= '0;
      form_q <= '0;
    end else if (upd) begin
      va_q   <= va_in;
      stat_q <= stat_in;
      form_q <= form_in;
    end
  end
endmodule

// File: rtl/dtx_xlate.sv
module dtx_xlate
  import dtx_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 44,
  parameter int PA_IMPL = 41,
  parameter int VA_IMPL = 43,
  parameter int PG_SH   = 13,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 126,
  parameter int ASN_W   = 8,
  parameter int SZW     = 2,
  parameter int VPN_W   = VA_W - PG_SH,
  parameter int PPN_W   = PA_W - PG_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [SZW-1:0]    req_size,
  input  logic              req_store,
  input  logic              req_phys,
  input  logic              req_alt,
  input  logic              req_pte,
  input  logic              req_nofault,
  input  logic [ASN_W-1:0]  req_asn,
  input  logic [5:0]        req_opcode,
  input  logic [4:0]        req_ra,
  input  logic [1:0]        cur_mode,
  input  logic [1:0]        alt_mode,
  input  logic              sp_en,
  input  logic [VA_W-1:0]   pt_base,
  output logic [VPN_W-1:0]  lkp_vpn,
  output logic [ASN_W-1:0]  lkp_asn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [3:0]        tlb_rd_en,
  input  logic [3:0]        tlb_wr_en,
  input  logic              tlb_for,
  input  logic              tlb_fow,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_fault,
  output logic [VA_W-1:0]   flt_va,
  output logic [16:0]       flt_stat,
  output logic [VA_W-1:0]   flt_form
);
  localparam int LOW_W = (1 << SZW) - 1;

  logic              accept;
  logic              misaligned;
  logic [MODE_W-1:0] mode_eff;
  flt_e              fault_c;
  logic [NFLAG-1:0]  flags_c;
  logic [PA_W-1:0]   paddr_c;
  logic [STAT_W-1:0] stat_c;
  logic [VA_W-1:0]   form_c;
  logic              recordable;
  logic              upd;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign lkp_vpn   = req_va[VA_W-1:PG_SH];
  assign lkp_asn   = req_asn;
  assign mode_eff  = req_alt ? alt_mode : cur_mode;

  dtx_align #(.SZW(SZW), .LOW_W(LOW_W)) u_align (
    .size_code  (req_size),
    .va_lo      (req_va[LOW_W-1:0]),
    .misaligned (misaligned)
  );

  dtx_classify #(
    .VA_W(VA_W), .PA_W(PA_W), .PA_IMPL(PA_IMPL), .VA_IMPL(VA_IMPL),
    .PG_SH(PG_SH), .SP_LO(SP_LO), .SP_TAG(SP_TAG), .PPN_W(PPN_W)
  ) u_cls (
    .va         (req_va),
    .is_store   (req_store),
    .phys       (req_phys),
    .pte_load   (req_pte),
    .misaligned (misaligned),
    .mode_eff   (mode_eff),
    .sp_en      (sp_en),
    .hit        (tlb_hit),
    .ppn        (tlb_ppn),
    .rd_en      (tlb_rd_en),
    .wr_en      (tlb_wr_en),
    .f_or       (tlb_for),
    .f_ow       (tlb_fow),
    .fault      (fault_c),
    .flags      (flags_c),
    .paddr      (paddr_c)
  );

  dtx_status #(.VA_W(VA_W), .PG_SH(PG_SH)) u_stat (
    .opcode  (req_opcode),
    .ra      (req_ra),
    .flags   (flags_c),
    .va      (req_va),
    .pt_base (pt_base),
    .stat    (stat_c),
    .form    (form_c)
  );

  // Machine checks and clean results leave the fault registers alone.
  assign recordable = (fault_c != FLT_NONE) && (fault_c != FLT_MCHK);
  assign upd        = accept && recordable && !req_pte && !req_nofault;

  dtx_fault_regs #(.VA_W(VA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .va_in   (req_va),
    .stat_in (stat_c),
    .form_in (form_c),
    .va_q    (flt_va),
    .stat_q  (flt_stat),
    .form_q  (flt_form)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= paddr_c;
        rsp_fault <= fault_c;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtx_xlate_chk.sv
module dtx_xlate_chk #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 44,
  parameter int PA_IMPL = 41,
  parameter int SZW     = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic [SZW-1:0]  req_size,
  input logic            req_phys,
  input logic            req_pte,
  input logic            req_nofault,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_fault,
  input logic [VA_W-1:0] flt_va,
  input logic [16:0]     flt_stat,
  input logic [VA_W-1:0] flt_form
);
  localparam int LOW_W = (1 << SZW) - 1;

  logic             acc;
  logic [LOW_W-1:0] lo_mask;
  logic             misal;

  assign acc = req_valid && req_ready;
  always_comb lo_mask = LOW_W'((1 << req_size) - 1);
  assign misal = |(req_va[LOW_W-1:0] & lo_mask);

  // R1: a stalled result does not move
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R1: an accepted request produces a result on the next edge
  a_r1_fill: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R2: misalignment wins over everything
  a_r2_align_first: assert property (@(posedge clk) disable iff (!rst_n)
    acc && misal |=> rsp_fault == 3'd1);

  // R4: clean physical request passes the address through
  a_r4_phys_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !misal && req_phys && !(|req_va[VA_W-1:PA_IMPL])
    |=> rsp_fault == 3'd0 && rsp_paddr == $past(req_va[PA_W-1:0]));

  // R12: page-table loads and no-fault requests leave the fault registers
  a_r12_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_pte || req_nofault)
    |=> $stable(flt_va) && $stable(flt_stat) && $stable(flt_form));

  // R12: nothing records without an accepted request
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(flt_va) && $stable(flt_stat) && $stable(flt_form));
endmodule

bind dtx_xlate dtx_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PA_IMPL(PA_IMPL), .SZW(SZW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_va      (req_va),
  .req_size    (req_size),
  .req_phys    (req_phys),
  .req_pte     (req_pte),
  .req_nofault (req_nofault),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_paddr   (rsp_paddr),
  .rsp_fault   (rsp_fault),
  .flt_va      (flt_va),
  .flt_stat    (flt_stat),
  .flt_form    (flt_form)
);

// File: tb/sim_dtx_xlate.sv
`timescale 1ns/1ps
module sim_dtx_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [1:0]  req_size = '0;
  logic        req_store = 1'b0, req_phys = 1'b0, req_alt = 1'b0;
  logic        req_pte = 1'b0, req_nofault = 1'b0;
  logic [7:0]  req_asn = '0;
  logic [5:0]  req_opcode = '0;
  logic [4:0]  req_ra = '0;
  logic [1:0]  cur_mode = '0, alt_mode = '0;
  logic        sp_en = 1'b0;
  logic [47:0] pt_base = 48'h0000_0020_0000;
  logic [34:0] lkp_vpn;
  logic [7:0]  lkp_asn;
  logic        tlb_hit = 1'b0;
  logic [30:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
  logic        tlb_for = 1'b0, tlb_fow = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [43:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic [47:0] flt_va;
  logic [16:0] flt_stat;
  logic [47:0] flt_form;

  int n_chk = 0;
  int n_bad = 0;

  logic [47:0] sh_va = '0;
  logic [16:0] sh_stat = '0;
  logic [47:0] sh_form = '0;

  always #2.5 clk = ~clk;

  dtx_xlate u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result from the requirement text.
  task automatic model(output logic [2:0] f, output logic [43:0] pa,
                       output logic [5:0] fl, output string tag);
    logic [1:0] m;
    logic [43:0] xp;
    m = req_alt ? alt_mode : cur_mode;
    f = 3'd0; pa = '0; fl = '0; tag = "R10";
    if ((req_va[2:0] & 3'((1 << req_size) - 1)) != 0) begin
      f = 3'd1; fl[0] = req_store; tag = "R2";
    end else if (req_phys) begin
      pa = req_va[43:0]; tag = "R4";
      if (req_va[47:41] != 0) f = 3'd6;
    end else if (!(req_va[47:42] == 6'h00 || req_va[47:42] == 6'h3f)) begin
      f = 3'd5; fl = {1'b0, 1'b1, 2'b00, 1'b1, req_store}; tag = "R5";
    end else if (sp_en && req_va[47:41] == 7'h7e) begin
      tag = "R6";
      if (m == 2'd0) pa = {3'b000, req_va[40:0]};
      else begin f = 3'd4; fl = {4'b0000, 1'b1, req_store}; end
    end else if (!tlb_hit) begin
      f = req_pte ? 3'd2 : 3'd3; fl = {1'b1, 4'b0000, req_store}; tag = "R7";
    end else begin
      xp = {tlb_ppn, req_va[12:0]};
      pa = xp;
      if (req_store) begin
        tag = "R8";
        if (!tlb_wr_en[m]) begin f = 3'd4; fl = {2'b00, tlb_fow, 1'b0, 2'b11}; end
        else if (tlb_fow) begin f = 3'd5; fl = 6'b001001; end
      end else begin
        tag = "R9";
        if (!tlb_rd_en[m]) begin f = 3'd4; fl = {3'b000, tlb_for, 2'b10}; end
        else if (tlb_for) begin f = 3'd5; fl = 6'b000100; end
      end
      if (f == 3'd0 && xp[43:41] != 0) begin f = 3'd6; tag = "R10"; end
    end
  endtask

  task automatic run_one();
    logic [2:0] ef; logic [43:0] ep; logic [5:0] efl; string tag;
    @(negedge clk);
    req_valid = 1'b1; rsp_ready = 1'b1;
    #1;
    chk("R13 vpn", 64'(lkp_vpn), 64'(req_va[47:13]));
    chk("R13 asn", 64'(lkp_asn), 64'(req_asn));
    model(ef, ep, efl, tag);
    if (ef >= 3'd1 && ef <= 3'd5 && !req_pte && !req_nofault) begin
      sh_va = req_va;
      sh_stat = {req_opcode, req_ra, efl};               // R11 layout
      sh_form = pt_base | 48'({req_va[47:13], 3'b000});
    end
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R1 valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " fault"}, 64'(rsp_fault), 64'(ef));
    if (ef == 3'd0) chk({tag, " paddr"}, 64'(rsp_paddr), 64'(ep));
    chk("R12 va", 64'(flt_va), 64'(sh_va));
    chk("R11 R12 stat", 64'(flt_stat), 64'(sh_stat));
    chk("R12 form", 64'(flt_form), 64'(sh_form));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("reset flt_stat", 64'(flt_stat), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready idle", 64'(req_ready), 64'd1);

    // R2 / R4: size x low bits on physical requests
    for (int s = 0; s < 4; s++) begin
      for (int lo = 0; lo < 8; lo++) begin
        req_phys = 1'b1; req_size = 2'(s); req_store = 1'(lo & 1);
        req_va = 48'h0000_0123_4560 | 48'(lo);
        req_opcode = 6'(s * 8 + lo); req_ra = 5'(lo);
        run_one();
      end
    end
    // R4: machine check on high physical bit
    req_size = 2'd0; req_va = 48'h0200_0000_0000; run_one();
    req_va = 48'h0000_0000_0000; req_va[41] = 1'b1; run_one();

    // R3 / R8 / R9: hit permissions across modes
    req_phys = 1'b0; tlb_hit = 1'b1; req_size = 2'd3;
    for (int cm = 0; cm < 4; cm++)
      for (int am = 0; am < 4; am++)
        for (int al = 0; al < 2; al++)
          for (int st = 0; st < 2; st++)
            for (int ff = 0; ff < 4; ff++) begin
              cur_mode = 2'(cm); alt_mode = 2'(am); req_alt = 1'(al);
              req_store = 1'(st); tlb_for = 1'(ff & 1); tlb_fow = 1'(ff >> 1);
              tlb_rd_en = 4'(cm * 5 + am * 3 + ff);
              tlb_wr_en = 4'(am * 7 + cm + st);
              tlb_ppn = 31'(cm * 64 + am * 16 + ff + 1);
              req_va = 48'h0000_0456_7000 + 48'(cm * 8192 + am * 64 + ff * 8);
              req_nofault = ((cm + am + ff) % 5 == 0);
              req_pte = 1'b0;
              req_opcode = 6'(cm * 16 + am * 4 + ff); req_ra = 5'(st * 16 + ff);
              req_asn = 8'(cm * 4 + am);
              run_one();
            end
    req_nofault = 1'b0;

    // R10: permitted hit with out-of-range frame
    req_store = 1'b0; tlb_for = 1'b0; tlb_rd_en = 4'hf; req_alt = 1'b0;
    tlb_ppn = 31'h1000_0005; run_one();
    tlb_ppn = 31'h0fff_ffff; run_one();

    // R7: misses
    tlb_hit = 1'b0;
    for (int k = 0; k < 8; k++) begin
      req_pte = 1'(k & 1); req_nofault = 1'((k >> 1) & 1); req_store = 1'(k >> 2);
      req_va = 48'hffff_fff0_0000 + 48'(k * 8192);
      run_one();
    end
    req_pte = 1'b0; req_nofault = 1'b0;

    // R6: superpage window
    tlb_hit = 1'b1; tlb_ppn = 31'h42;
    for (int se = 0; se < 2; se++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 2; t++) begin
          sp_en = 1'(se); cur_mode = 2'(m); req_store = 1'(m & 1);
          tlb_rd_en = 4'hf; tlb_wr_en = 4'hf;
          req_va = {(t == 0) ? 7'h7e : 7'h7f, 41'h0_1234_5678};
          run_one();
        end
    sp_en = 1'b0;

    // R5: badly formed addresses
    req_va = 48'h0400_0000_0000; req_store = 1'b1; run_one();
    req_va = 48'h8000_0000_1000; req_store = 1'b0; run_one();
    req_va = 48'hfbff_ffff_0000; run_one();

    // R1: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_phys = 1'b1; req_size = 2'd0;
    req_va = 48'h0000_0000_0100; req_valid = 1'b1;
    @(posedge clk); #1;
    req_va = 48'h0000_0000_0200;
    @(negedge clk);
    chk("R1 full ready", 64'(req_ready), 64'd0);
    chk("R1 held paddr", 64'(rsp_paddr), 64'h100);
    @(negedge clk);
    chk("R1 still held", 64'(rsp_paddr), 64'h100);
    chk("R1 still valid", 64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R1 next result", 64'(rsp_paddr), 64'h200);
    chk("R1 next valid", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    chk("R1 drained", 64'(rsp_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule